// File: doc/BRIEF.md
# Multi-Cell Overvoltage Fault Qualifier

This block is the digital control core of a secondary overvoltage protector for a stack of two or three series cells. A single comparator path is shared among the cells. The block steers a sense multiplexer with its `sel` output and, on every tick of a slow oscillator, samples two comparator results for the selected cell:

- one taken at the trip level;
- one taken at the lower release level.

Each result is stored in a per-cell flag, and the decisions are made from these stored flags.

When any stored trip flag is set, the block starts a delay timer that counts oscillator ticks. The single active-high `fault_out` rises only if the overvoltage persists for the whole delay. The output is meant to gate an external transistor that blows a fuse. Once latched, the fault is held until every cell has dropped below the release level. That release level sits a hysteresis margin under the trip level.

Two fixed delays are available, nominally 4 s and 6.5 s. A test request replaces them with a short delay of about 15 ms. A cell-count select masks the top position when only two cells are fitted. All delays are parameters in milliseconds, together with the tick period in microseconds, so a scaled tick can be used. The comparator inputs and the mode selects are plain level signals with no handshake. The block has no data stream.

Top module: `ovq_top`

## Requirements
- R1: After reset `sel` is 0. `sel` advances by one at each `tick` and wraps from CELLS-1 to 0. At a tick, `cmp_trip` and `cmp_rel` are taken as the state of the cell named by `sel` before that tick.
- R2: A trip flag set at a tick starts qualification, and at least one cell is enough. `fault_out` rises at exactly the N-th later tick. N is DLY_A_MS*1000/TICK_US with `dly_sel`=0, and DLY_B_MS*1000/TICK_US with `dly_sel`=1, when `test_req` is low.
- R3: A synchronous reset (`rst` high) gives `fault_out`=0 and clears all stored flags. `fault_out` stays 0 whenever no fault is latched.
- R4: If the tripped cell is seen below the trip level before the delay expires, the timer is abandoned and `fault_out` stays 0. A later overvoltage waits the full delay again.
- R5: A latched fault stays high while any cell still reports `cmp_rel`=1, meaning that cell is above the release level. It falls once every cell has been sampled with `cmp_rel`=0.
- R6: With `three_cell`=0, the top position (index CELLS-1) can never start or hold a fault, and the lower cells still qualify normally.
- R7: With `test_req` high when qualification starts, the delay is TEST_MS*1000/TICK_US ticks. With `test_req` low, the normal delay is used again.
- R8: A change of `test_req` during qualification restarts the count from zero, with the delay chosen by the new `test_req` value.
- R9: The `dly_sel` value is captured when qualification starts. A later change has no effect on that qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oscillator tick, one clock wide |
| cmp_trip | input | 1 | Selected cell is above the trip level |
| cmp_rel | input | 1 | Selected cell is above the release level |
| test_req | input | 1 | Shortened-delay test request |
| dly_sel | input | 1 | 0: short normal delay, 1: long normal delay |
| three_cell | input | 1 | 1: three cells fitted, 0: two cells fitted |
| sel | output | SEL_W | Cell index driven to the sense multiplexer |
| fault_out | output | 1 | Qualified overvoltage, active high |

## Verification
The bench builds the block with CELLS=3, TICK_US=1000, DLY_A_MS=40, DLY_B_MS=65 and TEST_MS=15. This gives delays of 40, 65 and 15 ticks, so every delay can be counted tick by tick to its exact edge.

At that size the bench sweeps both delay options over every cell position. It then covers abort and re-qualification, the hysteresis hold, two-cell masking, and test-mode entry, exit and mid-count restarts in both directions.

// File: rtl/ovq_pkg.sv
package ovq_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_QUAL   = 2'd1,
    ST_OVER   = 2'd2
  } ovq_state_t;

  function automatic int ms_to_ticks(input int ms, input int tick_us);
    int t;
    t = (ms * 1000) / tick_us;
    return (t < 1) ? 1 : t;
  endfunction
endpackage

// File: rtl/ovq_scan.sv
module ovq_scan #(
  parameter int CELLS = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_trip,
  input  logic             cmp_rel,
  input  logic             three_cell,
  output logic [SEL_W-1:0] sel,
  output logic             any_over,
  output logic             all_rel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(CELLS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [CELLS-1:0] trip_q;
  logic [CELLS-1:0] rel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (tick) sel_q <= (sel_q == LAST) ? '0 : sel_q + 1'b1;
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam bit IS_TOP = (i == CELLS - 1);
    logic visit;
    logic live;
    assign visit = tick && (sel_q == SEL_W'(i));
    assign live  = IS_TOP ? three_cell : 1'b1;

    always_ff @(posedge clk) begin
      if (rst) begin
        trip_q[i] <= 1'b0;
        rel_q[i]  <= 1'b0;
      end else if (!live) begin
        trip_q[i] <= 1'b0;
        rel_q[i]  <= 1'b0;
      end else if (visit) begin
        trip_q[i] <= cmp_trip;
        rel_q[i]  <= cmp_rel;
      end
    end

    if (IS_TOP) begin : g_top_chk
      // R6: the top position is cleared while two cells are selected
      a_r6_top_masked: assert property (@(posedge clk) disable iff (rst)
        !three_cell |=> (!trip_q[i] && !rel_q[i]));
    end
  end

  assign sel      = sel_q;
  assign any_over = |trip_q;
  assign all_rel  = ~|rel_q;

  // R1: round-robin advance on tick, hold otherwise
  a_r1_sel_advance: assert property (@(posedge clk) disable iff (rst)
    tick |=> (sel == (($past(sel) == LAST) ? '0 : $past(sel) + 1'b1)));
  a_r1_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sel));
endmodule

// File: rtl/ovq_timer.sv
module ovq_timer #(
  parameter int CNT_W  = 13,
  parameter int TERM_R = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] term_in,
  input  logic             step,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      term_q <= CNT_W'(TERM_R);
    end else if (start) begin
      cnt_q  <= '0;
      term_q <= term_in;
    end else if (step && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = step && !start && (cnt_q == term_q - 1'b1);

  // R2: the count never passes the latched terminal value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < term_q);
endmodule

// File: rtl/ovq_ctrl.sv
module ovq_ctrl
  import ovq_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int TERM_A = 4000,
  parameter int TERM_B = 6500,
  parameter int TERM_T = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             any_over,
  input  logic             all_rel,
  input  logic             test_req,
  input  logic             dly_sel,
  input  logic             expire,
  output logic             start,
  output logic             step,
  output logic [CNT_W-1:0] term_sel,
  output logic             fault_out
);
  ovq_state_t st_q;
  logic       test_q;
  logic       fault_q;
  logic       test_chg;

  assign test_chg = (test_req != test_q);
  assign term_sel = test_req ? CNT_W'(TERM_T) : (dly_sel ? CNT_W'(TERM_B) : CNT_W'(TERM_A));
  assign start    = any_over && ((st_q == ST_NORMAL) || ((st_q == ST_QUAL) && test_chg));
  assign step     = (st_q == ST_QUAL) && any_over && tick && !test_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_NORMAL;
      test_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      test_q <= test_req;
      unique case (st_q)
        ST_NORMAL: if (any_over) st_q <= ST_QUAL;
        ST_QUAL: begin
          if (!any_over) st_q <= ST_NORMAL;
          else if (expire) begin
            st_q    <= ST_OVER;
            fault_q <= 1'b1;
          end
        end
        ST_OVER: if (all_rel) begin
          st_q    <= ST_NORMAL;
          fault_q <= 1'b0;
        end
        default: st_q <= ST_NORMAL;
      endcase
    end
  end

  assign fault_out = fault_q;

  // R4: losing every trip flag while qualifying abandons the timer
  a_r4_abort: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_QUAL && !any_over) |=> (st_q == ST_NORMAL && !fault_out));
  // R5: latched fault holds while any cell is above the release level
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (fault_out && !all_rel) |=> fault_out);
  // R2: the fault only rises on a tick edge, out of qualification
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_out) |-> ($past(tick) && $past(st_q) == ST_QUAL));
  // R3: no fault outside the latched state
  a_r3_low_unless_latched: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_OVER) |-> !fault_out);
endmodule

// File: rtl/ovq_top.sv
module ovq_top
  import ovq_pkg::*;
#(
  parameter int CELLS    = 3,
  parameter int TICK_US  = 1000,
  parameter int DLY_A_MS = 4000,
  parameter int DLY_B_MS = 6500,
  parameter int TEST_MS  = 15,
  parameter int SEL_W    = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_trip,
  input  logic             cmp_rel,
  input  logic             test_req,
  input  logic             dly_sel,
  input  logic             three_cell,
  output logic [SEL_W-1:0] sel,
  output logic             fault_out
);
  localparam int TERM_A   = ms_to_ticks(DLY_A_MS, TICK_US);
  localparam int TERM_B   = ms_to_ticks(DLY_B_MS, TICK_US);
  localparam int TERM_T   = ms_to_ticks(TEST_MS, TICK_US);
  localparam int TERM_MAX = (TERM_A > TERM_B) ? ((TERM_A > TERM_T) ? TERM_A : TERM_T)
                                              : ((TERM_B > TERM_T) ? TERM_B : TERM_T);
  localparam int CNT_W    = $clog2(TERM_MAX + 1);

  logic             any_over;
  logic             all_rel;
  logic             start;
  logic             step;
  logic             expire;
  logic [CNT_W-1:0] term_sel;

  ovq_scan #(.CELLS(CELLS), .SEL_W(SEL_W)) scan_i (
    .clk(clk), .rst(rst), .tick(tick), .cmp_trip(cmp_trip), .cmp_rel(cmp_rel),
    .three_cell(three_cell), .sel(sel), .any_over(any_over), .all_rel(all_rel)
  );

  ovq_ctrl #(.CNT_W(CNT_W), .TERM_A(TERM_A), .TERM_B(TERM_B), .TERM_T(TERM_T)) ctrl_i (
    .clk(clk), .rst(rst), .tick(tick), .any_over(any_over), .all_rel(all_rel),
    .test_req(test_req), .dly_sel(dly_sel), .expire(expire), .start(start),
    .step(step), .term_sel(term_sel), .fault_out(fault_out)
  );

  ovq_timer #(.CNT_W(CNT_W), .TERM_R(TERM_A)) timer_i (
    .clk(clk), .rst(rst), .start(start), .term_in(term_sel), .step(step), .expire(expire)
  );
endmodule

// File: tb/ovq_top_tb_top.sv
module ovq_top_tb_top;
  localparam int NA = 40, NB = 65, NT = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       test_req = 1'b0;
  logic       dly_sel = 1'b0;
  logic       three_cell = 1'b1;
  logic [2:0] ov = '0;
  logic [2:0] hi = '0;
  logic [1:0] sel;
  logic       fault_out;
  logic       cmp_trip, cmp_rel;
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign cmp_trip = (sel < 2'd3) ? ov[sel] : 1'b0;
  assign cmp_rel  = (sel < 2'd3) ? hi[sel] : 1'b0;

  ovq_top #(.CELLS(3), .TICK_US(1000), .DLY_A_MS(40), .DLY_B_MS(65), .TEST_MS(15)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cmp_trip(cmp_trip), .cmp_rel(cmp_rel),
    .test_req(test_req), .dly_sel(dly_sel), .three_cell(three_cell),
    .sel(sel), .fault_out(fault_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) do_tick();
  endtask

  task automatic tick_at(input int c);
    bit hit = 1'b0;
    int s;
    while (!hit) begin
      s = int'(sel);
      do_tick();
      if (s == c) hit = 1'b1;
    end
  endtask

  task automatic qualify(input int c, input int n, input string tag);
    ov[c] = 1'b1;
    hi[c] = 1'b1;
    tick_at(c);
    ticks(n - 1);
    check({tag, " low one tick before expiry"}, int'(fault_out), 0);
    do_tick();
    check({tag, " high at expiry"}, int'(fault_out), 1);
  endtask

  task automatic release_cell(input int c);
    ov[c] = 1'b0;
    ticks(3);
    check("R5 held above release level", int'(fault_out), 1);
    hi[c] = 1'b0;
    ticks(3);
    check("R5 released below release level", int'(fault_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R3 reset fault", int'(fault_out), 0);
    check("R1 reset sel", int'(sel), 0);
    for (int k = 0; k < 6; k++) begin
      do_tick();
      check("R1 round robin", int'(sel), (k + 1) % 3);
    end

    // R2: sweep both delay options over every cell
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 3; c++) begin
        dly_sel = d[0];
        qualify(c, d ? NB : NA, d ? "R2 long delay" : "R2 short delay");
        release_cell(c);
      end
    end
    dly_sel = 1'b0;

    // R4: abort before expiry, then a fresh full delay
    ov[0] = 1'b1; hi[0] = 1'b1;
    tick_at(0);
    ticks(20);
    ov[0] = 1'b0; hi[0] = 1'b0;
    tick_at(0);
    check("R4 aborted", int'(fault_out), 0);
    ticks(60);
    check("R4 stays low after abort", int'(fault_out), 0);
    qualify(0, NA, "R4 full delay after abort");
    release_cell(0);

    // R6: two-cell mode masks the top position
    three_cell = 1'b0;
    ov[2] = 1'b1; hi[2] = 1'b1;
    ticks(80);
    check("R6 top ignored", int'(fault_out), 0);
    qualify(1, NA, "R6 lower cell");
    ov[1] = 1'b0; hi[1] = 1'b0;
    ticks(3);
    check("R6 top cannot hold fault", int'(fault_out), 0);
    ov[2] = 1'b0; hi[2] = 1'b0;
    three_cell = 1'b1;

    // R7: test mode delay, then normal again
    test_req = 1'b1;
    @(negedge clk);
    qualify(2, NT, "R7 test delay");
    release_cell(2);
    test_req = 1'b0;
    @(negedge clk);
    qualify(2, NA, "R7 normal after test");
    release_cell(2);

    // R8: entering test mode mid-count restarts with the short delay
    ov[1] = 1'b1; hi[1] = 1'b1;
    tick_at(1);
    ticks(10);
    test_req = 1'b1;
    @(negedge clk);
    ticks(NT - 1);
    check("R8 restart into test low", int'(fault_out), 0);
    do_tick();
    check("R8 restart into test high", int'(fault_out), 1);
    release_cell(1);

    // R8: leaving test mode mid-count restarts with the normal delay
    ov[0] = 1'b1; hi[0] = 1'b1;
    tick_at(0);
    ticks(10);
    test_req = 1'b0;
    @(negedge clk);
    ticks(NA - 1);
    check("R8 restart into normal low", int'(fault_out), 0);
    do_tick();
    check("R8 restart into normal high", int'(fault_out), 1);
    release_cell(0);

    // R9: dly_sel captured at start
    dly_sel = 1'b0;
    ov[2] = 1'b1; hi[2] = 1'b1;
    tick_at(2);
    ticks(5);
    dly_sel = 1'b1;
    ticks(NA - 6);
    check("R9 low before captured delay", int'(fault_out), 0);
    do_tick();
    check("R9 captured delay kept", int'(fault_out), 1);
    release_cell(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule